// File: doc/BRIEF.md
# Vector Load Address Sequencer

This block turns one vector load operation into the stream of per-element memory requests that carry it out. A single start pulse captures the operation: a base address, an element size, the stride choice (element size or a supplied stride), whether offsets come from an index stream, a segment length, the vector length and a predicate mask with an optional invert. The block then walks the elements in ascending order. For every element whose predicate is set, it emits one request per segment field. Each request carries the byte address, the destination register (the destination base plus the field number) and the element slot.

Requests leave through a valid/ready handshake, at most one per cycle, and the block holds its outputs while the consumer stalls. In indexed mode the block reads one index value per element position from a second valid/ready stream, and it also reads the index of an element that the predicate turns off. When the last element has been handled or skipped, a one-cycle done pulse follows. Memory timing, returned data, packing of narrow elements and fault handling belong to neighbouring blocks.

Top module: `vload_seq`

## Requirements
- R1: While reset (rstN low) is applied and in the first cycle after it, reqValid, idxReady, done and busy are all 0.
- R2: With strideSel=0 the stride equals elemSize (in bytes). With indexed=0 the address of element i, field j is baseAddr + (i*(segLen+1)+j)*stride.
- R3: With strideSel=1 the stride is strideVal instead of elemSize, and the same address rule as R2 applies.
- R4: With indexed=1 the address of element i, field j is baseAddr + idx[i] + j*stride, where idx[i] is the i-th value taken from the index stream. Exactly vecLen index values are consumed, one per element position, including positions the predicate turns off. With indexed=0 idxReady stays 0.
- R5: Requests are ordered by ascending element, then by ascending field 0..segLen. Each request carries reqElem=i and reqReg=(destReg+j) mod 2^REGW.
- R6: Element i produces requests only when predMask[i] XOR predInv is 1. Otherwise it produces none.
- R7: While reqValid=1 and reqReady=0, reqValid stays 1 and reqAddr, reqReg and reqElem hold their values on the next cycle.
- R8: done is a single-cycle pulse. When the last element is active, it is high in the cycle after the final request handshake. With vecLen=0 it is high in the cycle after start and no request is emitted.
- R9: Address sums wrap modulo 2^XLEN, so negative strides (two's complement) and bases near the top or bottom of the space are valid.
- R10: A start pulse while busy=1 is ignored. The running operation keeps its captured parameters, even if the configuration inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the configuration and begin (used only while idle) |
| busy | output | 1 | An operation is in progress |
| baseAddr | input | XLEN | Base byte address |
| elemSize | input | ESZW | Element size in bytes |
| strideSel | input | 1 | 0: stride is elemSize; 1: stride is strideVal |
| strideVal | input | XLEN | Supplied stride (two's complement) |
| indexed | input | 1 | Take element offsets from the index stream |
| segLen | input | SEGW | Number of extra fields per element (fields 0..segLen) |
| vecLen | input | VLW | Number of elements, 0..VLMAX |
| predMask | input | VLMAX | Per-element predicate bits |
| predInv | input | 1 | Invert the predicate |
| destReg | input | REGW | Destination register base |
| idxValid | input | 1 | Index value available |
| idxData | input | XLEN | Index byte offset |
| idxReady | output | 1 | Index value is taken this cycle when idxValid is 1 |
| reqValid | output | 1 | Request present |
| reqReady | input | 1 | Consumer accepts the request |
| reqAddr | output | XLEN | Request byte address |
| reqReg | output | REGW | Destination register of the request |
| reqElem | output | ELW | Element slot of the request |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can land in the same cycle: a consumer stall holding a request, and a start pulse arriving while the block is busy with different configuration inputs on its pins. The bench provokes this by pulsing start with a foreign base address partway through a run under a pseudo-random ready pattern. It judges the run by requiring every handshaked address to match the originally captured parameters and every stalled request to stay unchanged. A second overlap is an element switched off by its predicate that still consumes its index in the same cycle that the element walk advances. Gaps in the index stream make this visible, and the bench checks it through the consumed-index count and the addresses of the elements that follow.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef struct packed {
    logic cfgLoad;
    logic elemEnter;
    logic enterIdx;
    logic fieldStep;
    logic elemStep;
  } vlsStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PICK = 2'd1,
    ST_EMIT = 2'd2,
    ST_FIN  = 2'd3
  } vlsState_t;

endpackage

// File: rtl/vls_dpath.sv
module vls_dpath
  import vls_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ESZW = 5,
  parameter int SEGW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  vlsStrobes_t      strb,
  input  logic [XLEN-1:0]  baseIn,
  input  logic [ESZW-1:0]  elemSizeIn,
  input  logic             strideSelIn,
  input  logic [XLEN-1:0]  strideValIn,
  input  logic [SEGW-1:0]  segLenIn,
  input  logic [XLEN-1:0]  idxData,
  output logic [XLEN-1:0]  curAddr
);

  logic [XLEN-1:0] baseR;
  logic [XLEN-1:0] strideR;
  logic [XLEN-1:0] stepR;
  logic [XLEN-1:0] elemBaseR;
  logic [XLEN-1:0] strideSel;
  logic [XLEN-1:0] fieldCount;

  always_comb begin
    strideSel  = strideSelIn ? strideValIn : XLEN'(elemSizeIn);
    fieldCount = XLEN'(segLenIn) + XLEN'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR     <= '0;
      strideR   <= '0;
      stepR     <= '0;
      elemBaseR <= '0;
      curAddr   <= '0;
    end else begin
      if (strb.cfgLoad) begin
        baseR     <= baseIn;
        strideR   <= strideSel;
        stepR     <= strideSel * fieldCount;
        elemBaseR <= baseIn;
      end else if (strb.elemStep) begin
        elemBaseR <= elemBaseR + stepR;
      end
      if (strb.elemEnter) begin
        curAddr <= strb.enterIdx ? (baseR + idxData) : elemBaseR;
      end else if (strb.fieldStep) begin
        curAddr <= curAddr + strideR;
      end
    end
  end

  // Consecutive fields of one element are one stride apart (R2, R3, R9)
  assert_field_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.fieldStep && !strb.elemEnter |=> curAddr == $past(curAddr) + $past(strideR));

  // Indexed entry lands on base plus the index taken (R4)
  assert_index_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.elemEnter && strb.enterIdx |=> curAddr == $past(baseR) + $past(idxData));

endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
#(
  parameter int VLMAX = 16,
  parameter int SEGW  = 3,
  parameter int REGW  = 5,
  parameter int ELW   = $clog2(VLMAX),
  parameter int VLW   = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             indexed,
  input  logic [SEGW-1:0]  segLen,
  input  logic [VLW-1:0]   vecLen,
  input  logic [VLMAX-1:0] predMask,
  input  logic             predInv,
  input  logic [REGW-1:0]  destReg,
  input  logic             idxValid,
  output logic             idxReady,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [REGW-1:0]  reqReg,
  output logic [ELW-1:0]   reqElem,
  output logic             done,
  output logic             busy,
  output vlsStrobes_t      strb
);

  vlsState_t        state, stateN;
  logic [ELW-1:0]   elemIdx, elemN;
  logic [SEGW-1:0]  fieldCnt, fieldN;
  logic [VLW-1:0]   vlR;
  logic [VLMAX-1:0] predR;
  logic [SEGW-1:0]  segR;
  logic [REGW-1:0]  destR;
  logic             idxR;
  logic             lastElem;
  logic             accept;

  assign lastElem = (VLW'(elemIdx) == vlR - VLW'(1));
  assign accept   = (state == ST_IDLE) && start;

  always_comb begin
    strb     = '0;
    idxReady = 1'b0;
    reqValid = 1'b0;
    done     = 1'b0;
    stateN   = state;
    elemN    = elemIdx;
    fieldN   = fieldCnt;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.cfgLoad = 1'b1;
          elemN        = '0;
          fieldN       = '0;
          stateN       = (vecLen == '0) ? ST_FIN : ST_PICK;
        end
      end
      ST_PICK: begin
        idxReady = idxR;
        if (!idxR || idxValid) begin
          if (predR[elemIdx]) begin
            strb.elemEnter = 1'b1;
            strb.enterIdx  = idxR;
            fieldN         = '0;
            stateN         = ST_EMIT;
          end else begin
            strb.elemStep = 1'b1;
            if (lastElem) stateN = ST_FIN;
            else          elemN  = elemIdx + ELW'(1);
          end
        end
      end
      ST_EMIT: begin
        reqValid = 1'b1;
        if (reqReady) begin
          if (fieldCnt == segR) begin
            strb.elemStep = 1'b1;
            if (lastElem) begin
              stateN = ST_FIN;
            end else begin
              elemN  = elemIdx + ELW'(1);
              stateN = ST_PICK;
            end
          end else begin
            strb.fieldStep = 1'b1;
            fieldN         = fieldCnt + SEGW'(1);
          end
        end
      end
      ST_FIN: begin
        done   = 1'b1;
        stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      elemIdx  <= '0;
      fieldCnt <= '0;
      vlR      <= '0;
      predR    <= '0;
      segR     <= '0;
      destR    <= '0;
      idxR     <= 1'b0;
    end else begin
      state    <= stateN;
      elemIdx  <= elemN;
      fieldCnt <= fieldN;
      if (accept) begin
        vlR   <= vecLen;
        predR <= predMask ^ {VLMAX{predInv}};
        segR  <= segLen;
        destR <= destReg;
        idxR  <= indexed;
      end
    end
  end

  assign busy    = (state != ST_IDLE);
  assign reqElem = elemIdx;
  assign reqReg  = destR + REGW'(fieldCnt);

  // A stalled request keeps its identity (R7)
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqElem) && $stable(reqReg));

  // done never lasts beyond one cycle (R8)
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // Only predicate-enabled elements reach the request port (R6)
  assert_pred_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> predR[reqElem]);

  // Element slot stays below the captured length (R5)
  assert_elem_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (VLW'(reqElem) < vlR));

  // Index stream untouched outside indexed mode (R4)
  assert_idx_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    idxReady |-> idxR && !reqValid);

endmodule

// File: rtl/vload_seq.sv
module vload_seq
  import vls_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VLMAX = 16,
  parameter int SEGW  = 3,
  parameter int REGW  = 5,
  parameter int ESZW  = 5,
  parameter int ELW   = $clog2(VLMAX),
  parameter int VLW   = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             busy,
  input  logic [XLEN-1:0]  baseAddr,
  input  logic [ESZW-1:0]  elemSize,
  input  logic             strideSel,
  input  logic [XLEN-1:0]  strideVal,
  input  logic             indexed,
  input  logic [SEGW-1:0]  segLen,
  input  logic [VLW-1:0]   vecLen,
  input  logic [VLMAX-1:0] predMask,
  input  logic             predInv,
  input  logic [REGW-1:0]  destReg,
  input  logic             idxValid,
  input  logic [XLEN-1:0]  idxData,
  output logic             idxReady,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [XLEN-1:0]  reqAddr,
  output logic [REGW-1:0]  reqReg,
  output logic [ELW-1:0]   reqElem,
  output logic             done
);

  vlsStrobes_t strb;

  vls_ctrl #(
    .VLMAX(VLMAX), .SEGW(SEGW), .REGW(REGW), .ELW(ELW), .VLW(VLW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .indexed(indexed),
    .segLen(segLen), .vecLen(vecLen), .predMask(predMask),
    .predInv(predInv), .destReg(destReg), .idxValid(idxValid),
    .idxReady(idxReady), .reqValid(reqValid), .reqReady(reqReady),
    .reqReg(reqReg), .reqElem(reqElem), .done(done), .busy(busy),
    .strb(strb)
  );

  vls_dpath #(
    .XLEN(XLEN), .ESZW(ESZW), .SEGW(SEGW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .baseIn(baseAddr),
    .elemSizeIn(elemSize), .strideSelIn(strideSel),
    .strideValIn(strideVal), .segLenIn(segLen), .idxData(idxData),
    .curAddr(reqAddr)
  );

  // Stalled address holds (R7)
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> $stable(reqAddr));

  // No request once done is signalled (R8)
  assert_quiet_at_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqValid && !idxReady);

endmodule

// File: tb/test_vload_seq.sv
module test_vload_seq;

  localparam int XLEN = 32, VLMAX = 16, SEGW = 3, REGW = 5, ESZW = 5;
  localparam int ELW = $clog2(VLMAX), VLW = $clog2(VLMAX + 1);

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic busy, idxReady, reqValid, done;
  logic [XLEN-1:0] baseAddr = '0, strideVal = '0, idxData = '0, reqAddr;
  logic [ESZW-1:0] elemSize = '0;
  logic strideSel = 1'b0, indexed = 1'b0, predInv = 1'b0;
  logic idxValid = 1'b0, reqReady = 1'b0;
  logic [SEGW-1:0] segLen = '0;
  logic [VLW-1:0] vecLen = '0;
  logic [VLMAX-1:0] predMask = '0;
  logic [REGW-1:0] destReg = '0, reqReg;
  logic [ELW-1:0] reqElem;

  vload_seq i_vload_seq (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .baseAddr(baseAddr),
    .elemSize(elemSize), .strideSel(strideSel), .strideVal(strideVal),
    .indexed(indexed), .segLen(segLen), .vecLen(vecLen), .predMask(predMask),
    .predInv(predInv), .destReg(destReg), .idxValid(idxValid),
    .idxData(idxData), .idxReady(idxReady), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqReg(reqReg),
    .reqElem(reqElem), .done(done)
  );

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  // scenario configuration
  logic [XLEN-1:0] cBase, cStrideVal;
  logic [ESZW-1:0] cEsz;
  logic cStrideSel, cIndexed, cInv, cIdxGap;
  int cSeg, cVl, cRd, cReadyMode, cPokeAt;
  logic [VLMAX-1:0] cMask;
  logic [XLEN-1:0] idxList [VLMAX];
  logic [15:0] lfsr = 16'hACE1;

  logic [XLEN-1:0] expAddr [256];
  int expReg [256];
  int expElem [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runCase(input string tag);
    int expN = 0, hs = 0, idxPtr = 0, cyc = 0, lastHsCyc = -1, doneCyc = -1;
    logic [XLEN-1:0] stride, off, prevAddr;
    logic [REGW-1:0] prevReg;
    logic [ELW-1:0] prevElem;
    bit prevStall = 1'b0, lastActive;
    stride = cStrideSel ? cStrideVal : XLEN'(cEsz);
    for (int i = 0; i < cVl; i++) begin
      if (cMask[i] ^ cInv) begin
        for (int j = 0; j <= cSeg; j++) begin
          off = cIndexed ? idxList[i] : XLEN'(i * (cSeg + 1)) * stride;
          expAddr[expN] = cBase + off + XLEN'(j) * stride;
          expReg[expN]  = (cRd + j) % 32;
          expElem[expN] = i;
          expN++;
        end
      end
    end
    lastActive = (cVl > 0) && (cMask[cVl-1] ^ cInv);
    @(negedge clk);
    baseAddr = cBase; elemSize = cEsz; strideSel = cStrideSel;
    strideVal = cStrideVal; indexed = cIndexed; segLen = SEGW'(cSeg);
    vecLen = VLW'(cVl); predMask = cMask; predInv = cInv; destReg = REGW'(cRd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 2000) begin
      if (done) begin doneCyc = cyc; break; end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqReady = (cReadyMode == 0) ? 1'b1 : lfsr[0];
      idxValid = cIdxGap ? ((cyc % 3) != 1) : 1'b1;
      idxData  = (idxPtr < VLMAX) ? idxList[idxPtr] : '0;
      if (cPokeAt == cyc) begin
        // R10: start with foreign inputs while busy must be ignored
        start = 1'b1; baseAddr = 32'hDEAD_0000; strideVal = 32'h4444;
        vecLen = VLW'(1); predMask = '0;
      end else begin
        start = 1'b0; baseAddr = cBase; strideVal = cStrideVal;
        vecLen = VLW'(cVl); predMask = cMask;
      end
      if (reqValid) begin
        if (prevStall) begin
          chk(reqAddr == prevAddr, "R7", {tag, " stalled addr"}, reqAddr, prevAddr);
          chk(reqReg == prevReg && reqElem == prevElem, "R7", {tag, " stalled slot"},
              {reqReg, 8'h0, XLEN'(reqElem)}, {prevReg, 8'h0, XLEN'(prevElem)});
        end
        if (reqReady) begin
          if (hs < expN) begin
            chk(reqAddr == expAddr[hs], "R2/R3/R4/R9", {tag, " addr"}, reqAddr, expAddr[hs]);
            chk(int'(reqReg) == expReg[hs], "R5", {tag, " reg"}, XLEN'(reqReg), XLEN'(expReg[hs]));
            chk(int'(reqElem) == expElem[hs], "R5/R6", {tag, " elem"}, XLEN'(reqElem), XLEN'(expElem[hs]));
          end else begin
            chk(1'b0, "R6", {tag, " extra request"}, reqAddr, '0);
          end
          hs++;
          lastHsCyc = cyc;
        end
        prevStall = !reqReady; prevAddr = reqAddr; prevReg = reqReg; prevElem = reqElem;
      end else begin
        if (prevStall) chk(1'b0, "R7", {tag, " valid dropped in stall"}, 0, 1);
        prevStall = 1'b0;
      end
      if (!cIndexed && idxReady) chk(1'b0, "R4", {tag, " idxReady outside indexed"}, 1, 0);
      if (idxReady && idxValid) idxPtr++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; reqReady = 1'b0; idxValid = 1'b0;
    chk(doneCyc >= 0, "R8", {tag, " done seen"}, XLEN'(doneCyc), 0);
    chk(hs == expN, "R5/R6", {tag, " request count"}, XLEN'(hs), XLEN'(expN));
    chk(idxPtr == (cIndexed ? cVl : 0), "R4", {tag, " indices consumed"},
        XLEN'(idxPtr), XLEN'(cIndexed ? cVl : 0));
    if (cVl == 0) chk(doneCyc == 0, "R8", {tag, " empty done timing"}, XLEN'(doneCyc), 0);
    else if (lastActive)
      chk(doneCyc == lastHsCyc + 1, "R8", {tag, " done after last request"},
          XLEN'(doneCyc), XLEN'(lastHsCyc + 1));
    @(negedge clk);
    chk(!done && !busy, "R8", {tag, " single pulse, idle after"}, {done, busy}, 0);
  endtask

  task automatic setDefaults();
    cBase = '0; cStrideVal = '0; cEsz = 5'd4; cStrideSel = 0; cIndexed = 0;
    cInv = 0; cIdxGap = 0; cSeg = 0; cVl = 0; cRd = 0; cReadyMode = 0;
    cPokeAt = -1; cMask = '1;
    for (int k = 0; k < VLMAX; k++) idxList[k] = '0;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(!reqValid && !idxReady && !done && !busy, "R1", "during reset",
        {reqValid, idxReady, done, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqValid && !idxReady && !done && !busy, "R1", "after reset",
        {reqValid, idxReady, done, busy}, 0);
  endtask

  task automatic testUnitStride();   // R2 R5
    setDefaults();
    cBase = 32'h1000; cEsz = 5'd4; cVl = 16; cRd = 8;
    runCase("R2 unit");
  endtask

  task automatic testConstStride();  // R3 R7 R10, register number wrap R5
    setDefaults();
    cBase = 32'h2000; cEsz = 5'd8; cStrideSel = 1; cStrideVal = 32'h30;
    cSeg = 2; cVl = 4; cRd = 30; cReadyMode = 1; cPokeAt = 5;
    runCase("R3 const");
  endtask

  task automatic testIndexed();      // R4 R6
    setDefaults();
    cBase = 32'h8000_0000; cEsz = 5'd2; cIndexed = 1; cIdxGap = 1;
    cSeg = 1; cVl = 6; cMask = 16'h002D; cRd = 4; cReadyMode = 1;
    idxList[0] = 32'h40; idxList[1] = 32'h10; idxList[2] = 32'h300;
    idxList[3] = 32'h8; idxList[4] = 32'h1000; idxList[5] = 32'h22;
    runCase("R4 indexed");
  endtask

  task automatic testInvertWrap();   // R6 R9
    setDefaults();
    cBase = 32'h10; cStrideSel = 1; cStrideVal = 32'hFFFF_FFF8;
    cSeg = 1; cVl = 5; cMask = 16'h000A; cInv = 1; cRd = 1;
    runCase("R6 R9 invert wrap");
  endtask

  task automatic testEmpty();        // R8
    setDefaults();
    cBase = 32'h4000; cVl = 0;
    runCase("R8 empty");
  endtask

  task automatic testLastSkipped();  // R6 R8
    setDefaults();
    cBase = 32'h3000; cEsz = 5'd1; cSeg = 3; cVl = 3; cMask = 16'h0003; cRd = 2;
    runCase("R8 last skipped");
  endtask

  initial begin
    int cycles = 0;
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        miscompares++; vectors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    setDefaults();
    testReset();
    testUnitStride();
    testConstStride();
    testIndexed();
    testInvertWrap();
    testEmpty();
    testLastSkipped();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule